// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block guards a small 8-bit controller against runaway software. It starts out disarmed after every reset. Software arms it by writing two key bytes in a row to a write-only service register. From then on a hidden counter advances once per machine cycle. Software keeps the controller alive by repeating the same two-byte sequence, which clears the counter. If the counter runs out first, the block raises a reset request for a fixed number of oscillator periods. It also returns to the disarmed state.

The clock is the oscillator period. A machine-cycle enable marks the clocks on which counting may happen. Power-down stops counting. Idle mode stops counting only when the idle-freeze control bit is set. A reset-out disable bit keeps an overflow from raising the reset request. Software can never disarm the block, read the counter or write it.

Top module: `wdog_guard`

## Requirements
- R1: After reset `wd_armed` and `wd_reset` are low, and machine-cycle ticks have no effect while disarmed: no reset request ever appears.
- R2: A strobed write of 0x1E followed by a strobed write of 0xE1 arms the block. `wd_armed` is high from the clock edge that takes the second write.
- R3: Any strobed write that is not the expected next key restarts the sequence detector. A 0x1E written after 0x1E counts as a fresh first key. Data presented without `svc_wr` is ignored.
- R4: Once high, `wd_armed` stays high whatever software writes. Only `rst_n` or a counter overflow clears it.
- R5: While armed, the counter advances by one on each clock where `mc_tick` is high and counting is not frozen.
- R6: The complete key sequence written while armed clears the counter. An overflow happens on the (2^CNT_W - 1)-th counted tick after the last clear, and never earlier.
- R7: On overflow, `wd_reset` goes high at the next clock edge and stays high for exactly PULSE_LEN clocks. `wd_armed` drops at the same edge.
- R8: When `rstout_dis` is high at the overflow, no reset request is raised, but the block still disarms.
- R9: While `pdown_mode` is high the counter holds its value.
- R10: While `idle_mode` is high, counting continues if `idle_freeze` is 0. If `idle_freeze` is 1, counting pauses and later resumes from the held value. `idle_freeze` has no effect outside idle.
- R11: A completing service write on the same clock as the final tick wins: the counter clears and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| svc_wr | input | 1 | Write strobe for the service register |
| svc_data | input | 8 | Byte written to the service register |
| mc_tick | input | 1 | Machine-cycle enable, one clock wide |
| idle_mode | input | 1 | Controller is in idle mode |
| pdown_mode | input | 1 | Controller is in power-down mode |
| idle_freeze | input | 1 | 1: pause counting during idle |
| rstout_dis | input | 1 | 1: suppress the reset request on overflow |
| wd_reset | output | 1 | Reset request pulse |
| wd_armed | output | 1 | Watchdog is armed |

## Verification
The bench sweeps the service point across every tick position of a shortened counter. A design whose overflow came one tick early or late, or whose service failed to clear, would raise a reset inside a window that must stay quiet. Broken key sequences check the detector: a stray byte between the keys, a repeated first key and unstrobed data. A detector that remembered stale state would arm when it must not. Freeze checks count ticks across power-down and idle, so a design that kept counting, or restarted from zero, would put the overflow on the wrong tick. The bench also measures the reset pulse width, drives a same-cycle service and final tick, and overflows with the reset output disabled, which must still disarm.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'h1E;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'hE1;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_GOT_1 = 1'b1
    } seq_state_e;

endpackage

// File: rtl/wdog_seq_detect.sv
module wdog_seq_detect
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [KEY_W-1:0] data_i,
    output logic             done_o
);

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        done_o = 1'b0;
        if (wr_i) begin
            if (data_i == KEY_FIRST) begin
                r_d.state = SEQ_GOT_1;
            end else if (r_q.state == SEQ_GOT_1 && data_i == KEY_SECOND) begin
                r_d.state = SEQ_IDLE;
                done_o    = 1'b1;
            end else begin
                r_d.state = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SEQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: a completed sequence always leaves the detector waiting for a new first key
    assert_done_resets_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (r_q.state == SEQ_IDLE));

    // R3: a strobed byte other than the first key never leaves the detector primed
    assert_stray_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && data_i != KEY_FIRST) |=> (r_q.state == SEQ_IDLE));

    // R3: without a strobe the detector state is held
    assert_no_strobe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(r_q.state));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int unsigned CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic service_i,
    input  logic tick_i,
    input  logic idle_i,
    input  logic pdown_i,
    input  logic idle_freeze_i,
    output logic armed_o,
    output logic ovf_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_q, r_d;
    logic      frozen;
    logic      step;

    always_comb begin
        frozen = pdown_i || (idle_i && idle_freeze_i);
        step   = r_q.armed && tick_i && !frozen;
        r_d    = r_q;
        ovf_o  = 1'b0;
        if (service_i) begin
            r_d.armed = 1'b1;
            r_d.cnt   = '0;
        end else if (step) begin
            if (r_q.cnt == CNT_LAST) begin
                ovf_o     = 1'b1;
                r_d.armed = 1'b0;
                r_d.cnt   = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.armed <= 1'b0;
            r_q.cnt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign armed_o = r_q.armed;

    // R4: armed stays set unless an overflow occurs
    assert_armed_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.armed && !ovf_o) |=> r_q.armed);

    // R5: while disarmed and not being armed, the count stays at zero
    assert_idle_count_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.armed && !service_i) |=> (r_q.cnt == '0));

    // R9: power-down holds the count
    assert_pdown_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown_i && !service_i) |=> $stable(r_q.cnt));

    // R10: idle with freeze set holds the count
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && idle_freeze_i && !service_i) |=> $stable(r_q.cnt));

    // R11: a service in the same clock never yields an overflow
    assert_service_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        service_i |-> !ovf_o);

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic dis_i,
    output logic rst_o
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_LEN);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_regs_t;

    pulse_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (ovf_i && !dis_i) begin
            r_d.left = PULSE_INIT;
        end else if (r_q.left != '0) begin
            r_d.left = r_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.left <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rst_o = (r_q.left != '0);

    // R7: an enabled overflow raises the request at the next edge
    assert_pulse_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && !dis_i) |=> rst_o);

    // R8: a disabled overflow on a quiet output keeps it quiet
    assert_dis_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_i && dis_i && !rst_o) |=> !rst_o);

    // R7: the request only rises after an overflow
    assert_rise_needs_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_o && !ovf_i) |=> !rst_o);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned PULSE_LEN = 98
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    input  logic       mc_tick,
    input  logic       idle_mode,
    input  logic       pdown_mode,
    input  logic       idle_freeze,
    input  logic       rstout_dis,
    output logic       wd_reset,
    output logic       wd_armed
);

    logic seq_done;
    logic ovf;

    wdog_seq_detect u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (svc_wr),
        .data_i (svc_data),
        .done_o (seq_done)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .service_i     (seq_done),
        .tick_i        (mc_tick),
        .idle_i        (idle_mode),
        .pdown_i       (pdown_mode),
        .idle_freeze_i (idle_freeze),
        .armed_o       (wd_armed),
        .ovf_o         (ovf)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf_i (ovf),
        .dis_i (rstout_dis),
        .rst_o (wd_reset)
    );

    // R7: an overflow disarms the block at the same edge that starts the pulse
    assert_ovf_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !seq_done) |=> !wd_armed);

    // R1: a disarmed block never produces an overflow
    assert_no_ovf_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_armed |-> !ovf);

endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW   = 4;
    localparam int PLEN = 5;
    localparam int TMAX = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       mc_tick = 1'b0;
    logic       idle_mode = 1'b0;
    logic       pdown_mode = 1'b0;
    logic       idle_freeze = 1'b0;
    logic       rstout_dis = 1'b0;
    logic       wd_reset;
    logic       wd_armed;

    int checks = 0;
    int failures = 0;
    int hi_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_guard #(.CNT_W(CW), .PULSE_LEN(PLEN)) u_wdog_guard (
        .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .svc_data(svc_data),
        .mc_tick(mc_tick), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
        .idle_freeze(idle_freeze), .rstout_dis(rstout_dis),
        .wd_reset(wd_reset), .wd_armed(wd_armed)
    );

    always @(negedge clk) if (wd_reset) hi_cnt++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hi_cnt = 0;
    endtask

    task automatic wr(input logic [7:0] b);
        svc_wr = 1'b1;
        svc_data = b;
        @(negedge clk);
        svc_wr = 1'b0;
        svc_data = 8'h00;
    endtask

    task automatic service();
        wr(8'h1E);
        wr(8'hE1);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            mc_tick = 1'b1;
            @(negedge clk);
            mc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state and ticks while disarmed
        check("R1 armed after reset", wd_armed, 0);
        check("R1 reset out after reset", wd_reset, 0);
        ticks(3 * TMAX);
        check("R1 no pulse while disarmed", hi_cnt, 0);
        check("R1 still disarmed", wd_armed, 0);

        // R3 broken sequences
        wr(8'hE1);
        check("R3 lone second key", wd_armed, 0);
        wr(8'h1E); wr(8'h00); wr(8'hE1);
        check("R3 stray byte between keys", wd_armed, 0);
        svc_data = 8'h1E; @(negedge clk); svc_data = 8'hE1; @(negedge clk); svc_data = 8'h00;
        check("R3 unstrobed data ignored", wd_armed, 0);
        wr(8'h1E); wr(8'h1E); wr(8'hE1);
        check("R3 repeated first key restarts", wd_armed, 1);

        // R2 clean arm after reset
        do_reset();
        wr(8'h1E);
        check("R2 not armed after first key", wd_armed, 0);
        wr(8'hE1);
        check("R2 armed after second key", wd_armed, 1);

        // R4 software cannot disarm
        wr(8'h00); wr(8'hE1); wr(8'hFF); wr(8'h1E); wr(8'h55);
        check("R4 armed after stray writes", wd_armed, 1);

        // R6 sweep of service position
        for (int k = 0; k < TMAX; k++) begin
            service();
            ticks(k);
            service();
            ticks(TMAX - 1);
            check($sformatf("R6 no early overflow k=%0d", k), hi_cnt, 0);
            check($sformatf("R6 armed k=%0d", k), wd_armed, 1);
        end

        // R5 R7 overflow and pulse width
        service();
        ticks(TMAX - 1);
        check("R5 quiet before last tick", wd_reset, 0);
        mc_tick = 1'b1; @(negedge clk); mc_tick = 1'b0;
        check("R7 reset high after overflow", wd_reset, 1);
        check("R7 disarmed after overflow", wd_armed, 0);
        repeat (PLEN + 5) @(negedge clk);
        check("R7 pulse length", hi_cnt, PLEN);
        ticks(2 * TMAX);
        check("R7 no second pulse once disarmed", hi_cnt, PLEN);

        // R8 reset out disabled
        do_reset();
        rstout_dis = 1'b1;
        service();
        ticks(TMAX);
        repeat (PLEN + 2) @(negedge clk);
        check("R8 no pulse when disabled", hi_cnt, 0);
        check("R8 still disarms", wd_armed, 0);
        rstout_dis = 1'b0;

        // R9 power-down freeze
        do_reset();
        service();
        ticks(10);
        pdown_mode = 1'b1; ticks(3 * TMAX); pdown_mode = 1'b0;
        ticks(TMAX - 11);
        check("R9 held during power-down", hi_cnt, 0);
        ticks(1);
        check("R9 overflow on resumed count", wd_reset, 1);

        // R10 idle with freeze set
        do_reset();
        idle_freeze = 1'b1;
        service();
        ticks(6);
        idle_mode = 1'b1; ticks(2 * TMAX); idle_mode = 1'b0;
        ticks(TMAX - 7);
        check("R10 paused in idle with freeze", hi_cnt, 0);
        ticks(1);
        check("R10 resumes from held value", wd_reset, 1);

        // R10 idle without freeze keeps counting
        do_reset();
        idle_freeze = 1'b0;
        service();
        idle_mode = 1'b1;
        ticks(TMAX - 1);
        check("R10 counting in idle, quiet", wd_reset, 0);
        ticks(1);
        check("R10 counting in idle, overflow", wd_reset, 1);
        idle_mode = 1'b0;

        // R11 service on the final tick wins
        do_reset();
        service();
        ticks(TMAX - 1);
        wr(8'h1E);
        svc_wr = 1'b1; svc_data = 8'hE1; mc_tick = 1'b1;
        @(negedge clk);
        svc_wr = 1'b0; svc_data = 8'h00; mc_tick = 1'b0;
        check("R11 no overflow on same-cycle service", wd_reset, 0);
        ticks(TMAX - 1);
        check("R11 count restarted from zero", hi_cnt, 0);
        ticks(1);
        check("R11 later overflow", wd_reset, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule